// File: doc/BRIEF.md
# Privilege-checked profiling limit register

This block holds the 64-bit control word for a trace buffer: the upper limit address of the buffer, a fill-mode selector, a control that freezes event counters, and an enable bit. Every read or write request first goes through an access-permission decoder. The decoder looks at the requester's privilege level, its security state, the debug halt and secure-debug-disable flags, the ownership and trap controls set up by the two higher levels, and the nested-virtualization bits. From these it decides whether the access reaches the register, is sent to a fixed memory offset, traps to level 2 or level 3, or is undefined.

The answer to each request comes back one clock later. It carries a one-hot outcome, a syndrome class and, for a direct read, the register contents. Writes that reach the register are cleaned before they are stored. The stored fields also drive configuration outputs for the buffer logic next to this block, including a single "discard all output" indication.

Top module: `prof_lim_reg`

## Requirements
- R1: The stored word keeps the limit in bits 63:12, the freeze control in bit 5, the fill mode in bits 2:1 and the enable in bit 0. `cfg_limit_addr` is the limit with twelve zero bits below it, which is the first byte past the end of the buffer. `cfg_fill_mode`, `cfg_freeze` and `cfg_enable` show the stored fields.
- R2: A write that reaches the register stores zero in bits 11:6 and 4:3, whatever value is written to them.
- R3: When `HAS_V1P2` is 0, a stored write clears bit 5. When `GRAN_LOG2` is greater than 12, a stored write clears limit bits `GRAN_LOG2-1`:12.
- R4: A synchronous reset clears the whole stored word, so the enable reads 0. It also drops `rsp_valid`.
- R5: `cfg_discard` is 1 when the enable is 0, or when the fill mode is 2'b10 and `HAS_V1P2` is 1. Otherwise it is 0, including for fill mode 2'b00 and the reserved codes 2'b01 and 2'b11.
- R6: An access at level 0 is undefined. An access at level 3 is always direct.
- R7: At level 1 the checks are taken in this priority order:
  1. The debug lock with a failing level-3 ownership check gives undefined, when `SDD_UNDEF_FIRST` is 1.
  2. A qualified fine-grained trap gives a trap to level 2.
  3. `el2_active` with `el2_own_lo`=0 gives a trap to level 2.
  4. A failing level-3 ownership check gives a trap to level 3, or undefined under the debug lock.
  5. The redirect check follows.
  6. If none of these applies, the access is direct.
- R8: The level-3 ownership check fails only when `el3_impl` is 1 and `el3_own` is not the pass value for the current state. The pass value is 2'b11 when `nonsecure` is 1 and 2'b01 when it is 0. The debug lock means `halted` and `sec_dbg_dis` are both 1.
- R9: At level 2 only the checks of steps 1 and 4 apply. Otherwise the access is direct.
- R10: At level 1, when steps 1 to 4 pass and `el2_active`, `virt_nv2` and `virt_nv` are all 1, the outcome is redirect. `rsp_offset` is then 12'h800, the register is unchanged and `rsp_rdata` is zero.
- R11: `rsp_outcome` is one-hot, with bit 4 undefined, bit 3 trap to level 2, bit 2 trap to level 3, bit 1 redirect and bit 0 direct. `rsp_class` is 6'h18 for a trap and 0 otherwise.
- R12: The response appears in the cycle after the request. `rsp_rdata` holds the register contents only for a direct read and is zero otherwise.
- R13: The fine-grained trap counts only when `el2_active` is 1 and either `el3_impl` is 0 or `fgt_enable` is 1. A read uses `fgt_rd_trap` and a write uses `fgt_wr_trap`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high warm reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write data |
| cur_el | input | 2 | Privilege level of the requester |
| nonsecure | input | 1 | Requester is in non-secure state |
| halted | input | 1 | Core is in debug halt |
| sec_dbg_dis | input | 1 | Secure debug disabled |
| el3_impl | input | 1 | Level 3 is implemented |
| el2_active | input | 1 | Level 2 is enabled in the current state |
| fgt_enable | input | 1 | Level-3 enable for fine-grained traps |
| fgt_rd_trap | input | 1 | Fine-grained trap for reads |
| fgt_wr_trap | input | 1 | Fine-grained trap for writes |
| el2_own_lo | input | 1 | Low bit of the level-2 buffer ownership field |
| el3_own | input | 2 | Level-3 buffer ownership field |
| virt_nv2 | input | 1 | Nested-virtualization memory-redirect bit |
| virt_nv | input | 1 | Nested-virtualization enable bit |
| rsp_valid | output | 1 | Response valid |
| rsp_outcome | output | 5 | One-hot outcome |
| rsp_class | output | 6 | Syndrome class |
| rsp_rdata | output | 64 | Read data |
| rsp_offset | output | 12 | Redirect memory offset |
| cfg_limit_addr | output | 64 | Limit byte address |
| cfg_fill_mode | output | 2 | Stored fill mode |
| cfg_freeze | output | 1 | Stored freeze control |
| cfg_enable | output | 1 | Stored enable |
| cfg_discard | output | 1 | All output is discarded |

## Verification
The assertions assume that every control input is a settled 0 or 1 in any cycle with `req_valid` high. They also assume that `cur_el` and the trap controls change only between requests and never during the cycle the decoder samples them. The stimulus meets this by driving every input on the falling clock edge. It sweeps every combination of the decoder inputs at one request per cycle, with the two fine-grained trap bits always set to opposite values. A second instance, built with the feature disabled and a 64 KB granule, receives the same stimulus and covers the masking variants.

// File: rtl/prof_lim_pkg.sv
package prof_lim_pkg;
  localparam int unsigned REG_W   = 64;
  localparam int unsigned LIM_LSB = 12;

  typedef logic [4:0] outcome_t;
  localparam outcome_t OC_DIRECT = 5'b00001;
  localparam outcome_t OC_REDIR  = 5'b00010;
  localparam outcome_t OC_TRAP3  = 5'b00100;
  localparam outcome_t OC_TRAP2  = 5'b01000;
  localparam outcome_t OC_UNDEF  = 5'b10000;

  localparam logic [5:0] EC_SYSREG = 6'h18;

  localparam logic [REG_W-1:0] RSVD_BITS  = 64'h0000_0000_0000_0FD8;
  localparam logic [REG_W-1:0] FREEZE_BIT = 64'h0000_0000_0000_0020;

  typedef struct packed {
    logic [1:0] el;
    logic       ns;
    logic       halted;
    logic       sdd;
    logic       el3_impl;
    logic       el2_on;
    logic       fgt_en;
    logic       fgt_rd;
    logic       fgt_wr;
    logic       e2_own0;
    logic [1:0] e3_own;
    logic       nv2;
    logic       nv;
  } ctx_t;
endpackage

// File: rtl/prof_lim_access_dec.sv
module prof_lim_access_dec
  import prof_lim_pkg::*;
#(
  parameter bit SDD_UNDEF_FIRST = 1'b1
) (
  input  ctx_t       ctx,
  input  logic       is_write,
  output outcome_t   outcome,
  output logic [5:0] syn_class
);
  logic own3_pass, own3_fail, dbg_lock, early_undef, fgt_hit, e2_trap, redir;

  always_comb begin
    own3_pass   = ctx.ns ? (ctx.e3_own == 2'b11) : (ctx.e3_own == 2'b01);
    own3_fail   = ctx.el3_impl && !own3_pass;
    dbg_lock    = ctx.halted && ctx.sdd;
    early_undef = SDD_UNDEF_FIRST && dbg_lock && own3_fail;
    fgt_hit     = ctx.el2_on && (!ctx.el3_impl || ctx.fgt_en) &&
                  (is_write ? ctx.fgt_wr : ctx.fgt_rd);
    e2_trap     = ctx.el2_on && !ctx.e2_own0;
    redir       = ctx.el2_on && ctx.nv2 && ctx.nv;
  end

  always_comb begin
    outcome = OC_DIRECT;
    unique case (ctx.el)
      2'd0: outcome = OC_UNDEF;
      2'd1: begin
        if (early_undef)    outcome = OC_UNDEF;
        else if (fgt_hit)   outcome = OC_TRAP2;
        else if (e2_trap)   outcome = OC_TRAP2;
        else if (own3_fail) outcome = dbg_lock ? OC_UNDEF : OC_TRAP3;
        else if (redir)     outcome = OC_REDIR;
        else                outcome = OC_DIRECT;
      end
      2'd2: begin
        if (early_undef)    outcome = OC_UNDEF;
        else if (own3_fail) outcome = dbg_lock ? OC_UNDEF : OC_TRAP3;
        else                outcome = OC_DIRECT;
      end
      default: outcome = OC_DIRECT;
    endcase
    syn_class = (outcome == OC_TRAP2 || outcome == OC_TRAP3) ? EC_SYSREG : 6'h00;
  end
endmodule

// File: rtl/prof_lim_wr_mask.sv
module prof_lim_wr_mask
  import prof_lim_pkg::*;
#(
  parameter bit          HAS_V1P2  = 1'b1,
  parameter int unsigned GRAN_LOG2 = 12
) (
  input  logic [REG_W-1:0] raw,
  output logic [REG_W-1:0] clean
);
  localparam logic [REG_W-1:0] GRAN_BITS =
    ((64'd1 << GRAN_LOG2) - 64'd1) & ~((64'd1 << LIM_LSB) - 64'd1);

  logic [REG_W-1:0] frz_clr;

  generate
    if (HAS_V1P2) begin : g_frz_keep
      assign frz_clr = '0;
    end else begin : g_frz_drop
      assign frz_clr = FREEZE_BIT;
    end
  endgenerate

  assign clean = raw & ~(RSVD_BITS | GRAN_BITS | frz_clr);
endmodule

// File: rtl/prof_lim_store.sv
module prof_lim_store
  import prof_lim_pkg::*;
#(
  parameter bit HAS_V1P2 = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_val,
  output logic [REG_W-1:0] q,
  output logic [REG_W-1:0] limit_addr,
  output logic [1:0]       fill_mode,
  output logic             freeze,
  output logic             enable,
  output logic             discard
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (wr_en) q <= wr_val;
  end

  assign limit_addr = {q[REG_W-1:LIM_LSB], {LIM_LSB{1'b0}}};
  assign fill_mode  = q[2:1];
  assign freeze     = q[5];
  assign enable     = q[0];
  assign discard    = !q[0] || (HAS_V1P2 && q[2:1] == 2'b10);

  AST_ENABLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !enable); // R4
  AST_RSVD_STAY_ZERO: assert property (@(posedge clk) disable iff (rst)
    (q & RSVD_BITS) == '0); // R2
  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(q)); // R10
endmodule

// File: rtl/prof_lim_reg.sv
module prof_lim_reg
  import prof_lim_pkg::*;
#(
  parameter bit          HAS_V1P2        = 1'b1,
  parameter int unsigned GRAN_LOG2       = 12,
  parameter bit          SDD_UNDEF_FIRST = 1'b1,
  parameter int unsigned OFF_W           = 12,
  parameter logic [11:0] REDIR_OFF       = 12'h800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [63:0]       req_wdata,
  input  logic [1:0]        cur_el,
  input  logic              nonsecure,
  input  logic              halted,
  input  logic              sec_dbg_dis,
  input  logic              el3_impl,
  input  logic              el2_active,
  input  logic              fgt_enable,
  input  logic              fgt_rd_trap,
  input  logic              fgt_wr_trap,
  input  logic              el2_own_lo,
  input  logic [1:0]        el3_own,
  input  logic              virt_nv2,
  input  logic              virt_nv,
  output logic              rsp_valid,
  output logic [4:0]        rsp_outcome,
  output logic [5:0]        rsp_class,
  output logic [63:0]       rsp_rdata,
  output logic [OFF_W-1:0]  rsp_offset,
  output logic [63:0]       cfg_limit_addr,
  output logic [1:0]        cfg_fill_mode,
  output logic              cfg_freeze,
  output logic              cfg_enable,
  output logic              cfg_discard
);
  ctx_t             ctx;
  outcome_t         dec_out;
  logic [5:0]       dec_class;
  logic [REG_W-1:0] clean_w, reg_q;
  logic             wr_en;

  assign ctx = '{el: cur_el, ns: nonsecure, halted: halted, sdd: sec_dbg_dis,
                 el3_impl: el3_impl, el2_on: el2_active, fgt_en: fgt_enable,
                 fgt_rd: fgt_rd_trap, fgt_wr: fgt_wr_trap, e2_own0: el2_own_lo,
                 e3_own: el3_own, nv2: virt_nv2, nv: virt_nv};

  prof_lim_access_dec #(.SDD_UNDEF_FIRST(SDD_UNDEF_FIRST)) u_dec (
    .ctx(ctx), .is_write(req_write), .outcome(dec_out), .syn_class(dec_class)
  );

  prof_lim_wr_mask #(.HAS_V1P2(HAS_V1P2), .GRAN_LOG2(GRAN_LOG2)) u_mask (
    .raw(req_wdata), .clean(clean_w)
  );

  assign wr_en = req_valid && req_write && (dec_out == OC_DIRECT);

  prof_lim_store #(.HAS_V1P2(HAS_V1P2)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_val(clean_w), .q(reg_q),
    .limit_addr(cfg_limit_addr), .fill_mode(cfg_fill_mode),
    .freeze(cfg_freeze), .enable(cfg_enable), .discard(cfg_discard)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_outcome <= '0;
      rsp_class   <= '0;
      rsp_rdata   <= '0;
      rsp_offset  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_outcome <= dec_out;
        rsp_class   <= dec_class;
        rsp_rdata   <= (!req_write && dec_out == OC_DIRECT) ? reg_q : '0;
        rsp_offset  <= (dec_out == OC_REDIR) ? OFF_W'(REDIR_OFF) : '0;
      end else begin
        rsp_outcome <= '0;
        rsp_class   <= '0;
        rsp_rdata   <= '0;
        rsp_offset  <= '0;
      end
    end
  end

  AST_LEVEL0_UNDEF: assert property (@(posedge clk) disable iff (rst)
    req_valid && cur_el == 2'd0 |=> rsp_outcome == OC_UNDEF); // R6
  AST_LEVEL3_DIRECT: assert property (@(posedge clk) disable iff (rst)
    req_valid && cur_el == 2'd3 |=> rsp_outcome == OC_DIRECT); // R6
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones(rsp_outcome) == 1); // R11
  AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && (rsp_outcome[3] || rsp_outcome[2]) |-> rsp_class == EC_SYSREG); // R11
  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R12
  AST_REDIR_OFFSET: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_outcome[1] |-> rsp_offset == OFF_W'(REDIR_OFF) && rsp_rdata == '0); // R10
endmodule

// File: tb/prof_lim_reg_test.sv
module prof_lim_reg_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, req_valid, req_write, nonsecure, halted, sec_dbg_dis, el3_impl;
  logic el2_active, fgt_enable, fgt_rd_trap, fgt_wr_trap, el2_own_lo, virt_nv2, virt_nv;
  logic [63:0] req_wdata;
  logic [1:0]  cur_el, el3_own;

  logic        rsp_valid, cfg_freeze, cfg_enable, cfg_discard;
  logic [4:0]  rsp_outcome;
  logic [5:0]  rsp_class;
  logic [63:0] rsp_rdata, cfg_limit_addr;
  logic [11:0] rsp_offset;
  logic [1:0]  cfg_fill_mode;

  logic        b_valid, b_freeze, b_enable, b_discard;
  logic [4:0]  b_outcome;
  logic [5:0]  b_class;
  logic [63:0] b_rdata, b_limit;
  logic [11:0] b_offset;
  logic [1:0]  b_fill;

  int checks = 0;
  int errors = 0;

  prof_lim_reg uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_wdata(req_wdata),
    .cur_el(cur_el), .nonsecure(nonsecure), .halted(halted), .sec_dbg_dis(sec_dbg_dis),
    .el3_impl(el3_impl), .el2_active(el2_active), .fgt_enable(fgt_enable),
    .fgt_rd_trap(fgt_rd_trap), .fgt_wr_trap(fgt_wr_trap), .el2_own_lo(el2_own_lo),
    .el3_own(el3_own), .virt_nv2(virt_nv2), .virt_nv(virt_nv),
    .rsp_valid(rsp_valid), .rsp_outcome(rsp_outcome), .rsp_class(rsp_class),
    .rsp_rdata(rsp_rdata), .rsp_offset(rsp_offset), .cfg_limit_addr(cfg_limit_addr),
    .cfg_fill_mode(cfg_fill_mode), .cfg_freeze(cfg_freeze), .cfg_enable(cfg_enable),
    .cfg_discard(cfg_discard));

  prof_lim_reg #(.HAS_V1P2(1'b0), .GRAN_LOG2(16)) uut_b (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_wdata(req_wdata),
    .cur_el(cur_el), .nonsecure(nonsecure), .halted(halted), .sec_dbg_dis(sec_dbg_dis),
    .el3_impl(el3_impl), .el2_active(el2_active), .fgt_enable(fgt_enable),
    .fgt_rd_trap(fgt_rd_trap), .fgt_wr_trap(fgt_wr_trap), .el2_own_lo(el2_own_lo),
    .el3_own(el3_own), .virt_nv2(virt_nv2), .virt_nv(virt_nv),
    .rsp_valid(b_valid), .rsp_outcome(b_outcome), .rsp_class(b_class),
    .rsp_rdata(b_rdata), .rsp_offset(b_offset), .cfg_limit_addr(b_limit),
    .cfg_fill_mode(b_fill), .cfg_freeze(b_freeze), .cfg_enable(b_enable),
    .cfg_discard(b_discard));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference outcome, built from the priority lists in the requirements
  function automatic logic [4:0] ref_outcome(
      input logic [1:0] el, input logic ns, input logic hl, input logic sd,
      input logic e3, input logic e2, input logic fen, input logic frd, input logic fwr,
      input logic own2, input logic [1:0] own3, input logic n2, input logic n0,
      input logic wr);
    logic lock, bad3, fg;
    lock = hl & sd;
    bad3 = e3 & (own3 != (ns ? 2'b11 : 2'b01));
    fg   = e2 & (~e3 | fen) & (wr ? fwr : frd);
    if (el == 2'd0) return 5'b10000;
    if (el == 2'd3) return 5'b00001;
    if (lock && bad3) return 5'b10000;
    if (el == 2'd1 && (fg || (e2 && !own2))) return 5'b01000;
    if (bad3) return 5'b00100;
    if (el == 2'd1 && e2 && n2 && n0) return 5'b00010;
    return 5'b00001;
  endfunction

  task automatic set_ctx(input logic [1:0] el, input logic ns, input logic hl, input logic sd,
      input logic e3, input logic e2, input logic fen, input logic frd, input logic fwr,
      input logic own2, input logic [1:0] own3, input logic n2, input logic n0);
    cur_el = el; nonsecure = ns; halted = hl; sec_dbg_dis = sd; el3_impl = e3;
    el2_active = e2; fgt_enable = fen; fgt_rd_trap = frd; fgt_wr_trap = fwr;
    el2_own_lo = own2; el3_own = own3; virt_nv2 = n2; virt_nv = n0;
  endtask

  // one access from level 3 (always direct); caller is at a falling edge
  task automatic el3_access(input logic wr, input logic [63:0] d);
    set_ctx(2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0);
    req_valid = 1'b1; req_write = wr; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] model, wd;
    logic [4:0]  eo;
    string       tag;
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
    set_ctx(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R4 rsp_valid", {63'd0, rsp_valid}, 64'd0);
    check("R4 enable", {63'd0, cfg_enable}, 64'd0);
    check("R4 limit", cfg_limit_addr, 64'd0);
    check("R5 discard when disabled", {63'd0, cfg_discard}, 64'd1);

    // masking: all ones written from level 3
    el3_access(1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R12 write rdata zero", rsp_rdata, 64'd0);
    el3_access(1'b0, 64'd0);
    check("R2 reserved bits cleared", rsp_rdata, 64'hFFFF_FFFF_FFFF_F027);
    check("R3 freeze and granule bits cleared", b_rdata, 64'hFFFF_FFFF_FFFF_0007);
    check("R1 limit address", cfg_limit_addr, 64'hFFFF_FFFF_FFFF_F000);
    check("R1 fields", {59'd0, cfg_freeze, cfg_fill_mode, cfg_enable, 1'b0}, 64'h1E);
    check("R5 reserved mode not discard", {63'd0, cfg_discard}, 64'd0);

    el3_access(1'b1, 64'h0000_1234_5678_9005);  // fill mode 10, enabled
    check("R5 discard mode", {63'd0, cfg_discard}, 64'd1);
    check("R5 discard mode without feature", {63'd0, b_discard}, 64'd0);
    el3_access(1'b1, 64'h0000_1234_5678_9001);  // fill mode 00, enabled
    check("R5 fill mode", {63'd0, cfg_discard}, 64'd0);
    check("R1 limit value", cfg_limit_addr, 64'h0000_1234_5678_9000);

    // R10: redirected write leaves the register alone
    set_ctx(2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 1'b1, 1'b1);
    req_valid = 1'b1; req_write = 1'b1; req_wdata = 64'hDEAD_0000_0000_0000;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 outcome", {59'd0, rsp_outcome}, 64'h02);
    check("R10 offset", {52'd0, rsp_offset}, 64'h800);
    el3_access(1'b0, 64'd0);
    check("R10 register kept", rsp_rdata, 64'h0000_1234_5678_9001);
    model = 64'h0000_1234_5678_9001;

    // R13: direction selects the trap input
    set_ctx(2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0);
    req_valid = 1'b1; req_write = 1'b1; req_wdata = model;
    @(negedge clk);
    check("R13 write ignores read trap", {59'd0, rsp_outcome}, 64'h01);
    req_write = 1'b0;
    @(negedge clk);
    check("R13 read trap", {59'd0, rsp_outcome}, 64'h08);
    check("R11 trap class", {58'd0, rsp_class}, 64'h18);
    req_valid = 1'b0;

    // exhaustive sweep of the decoder inputs (R6 R7 R8 R9 R10 R11 R12 R13)
    for (int i = 0; i < 32768; i++) begin
      logic [14:0] k;
      k  = 15'(i);
      wd = {16'(i) ^ 16'hA5C3, 16'(i * 7), 16'(i * 13) ^ 16'h3C3C, 16'(i)};
      set_ctx(k[1:0], k[2], k[3], k[4], k[5], k[6], k[7], k[8], ~k[8], k[9],
              k[11:10], k[12], k[13]);
      req_valid = 1'b1; req_write = k[14]; req_wdata = wd;
      eo = ref_outcome(k[1:0], k[2], k[3], k[4], k[5], k[6], k[7], k[8], ~k[8], k[9],
                       k[11:10], k[12], k[13], k[14]);
      @(negedge clk);
      tag = (k[1:0] == 2'd1) ? "R7" : (k[1:0] == 2'd2) ? "R9" : "R6";
      checks++;
      if (!rsp_valid || rsp_outcome !== eo ||
          rsp_class !== ((eo[3] | eo[2]) ? 6'h18 : 6'h00) ||
          rsp_offset !== (eo[1] ? 12'h800 : 12'h000) ||
          rsp_rdata !== ((eo[0] && !k[14]) ? model : 64'd0)) begin
        errors++;
        $display("FAIL %s sweep %0d: actual %b/%h/%h/%h expected %b/%h/%h", tag, i,
                 rsp_outcome, rsp_class, rsp_offset, rsp_rdata, eo, model,
                 (eo[1] ? 12'h800 : 12'h000));
      end
      if (eo[0] && k[14]) model = wd & ~64'h0000_0000_0000_0FD8;
    end
    req_valid = 1'b0;
    @(negedge clk);
    check("R12 idle response", {63'd0, rsp_valid}, 64'd0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule